// File: doc/BRIEF.md
# Branch Target Prediction Unit

This block sits in the fetch stage of a multithreaded in-order pipeline and turns each control instruction into a taken/not-taken guess and a next fetch address. It joins three structures: a table of 2-bit saturating direction counters for conditional branches, a circular return-address stack kept separately for each hardware thread, and a direct-mapped branch target buffer whose entries match on the address-space identifier. Because entries match on that identifier and not on the thread number, threads running in one address space share learned targets.

A request carries the instruction address, its type flags, any target encoded in the instruction, the address-space identifier and the thread number. One cycle later the unit returns its decision, the target, and a repair record. The record holds whether the stack was popped, the popped slot and value, and whether a call pushed. A separate training port lets the execute stage move the direction counters and write target-buffer entries. Five event counters count lookups, conditional predictions, buffer probes, buffer hits and stack uses. The hit rate is the hit count times 100, divided by the probe count.

Top module: `brp_unit`

## Requirements
- R1: After reset, rsp_valid is 0, all five event counters read 0, every direction counter is weakly not-taken (2'b01), every stack is empty and the target buffer holds no valid entry.
- R2: A request with neither req_cond nor req_uncond set gives no response, changes no counter and does not push or pop any stack, even if req_call or req_ret is set.
- R3: A call on the taken path pushes PC + 2×INST_BYTES onto its thread's stack when DELAY_SLOT is 1 (PC + INST_BYTES when 0) and sets rsp_was_call.
- R4: A direct unconditional call is predicted taken with the instruction's own target (req_direct_tgt) and never counts a buffer hit, though it counts a buffer probe.
- R5: A return whose thread stack is not empty is predicted taken with the popped value as target, sets rsp_used_ras, and reports the popped slot index and value.
- R6: A return whose thread stack is empty is predicted not taken with target PC + INST_BYTES, and pops nothing.
- R7: Every other taken guess probes the target buffer with PC and ASID. It hits only when the entry is valid and both the ASID and every PC bit outside the index match. A miss turns the guess into not taken with target PC + INST_BYTES. The thread number plays no part in the match.
- R8: A conditional branch takes its direction from bit 1 of a 2-bit counter indexed by PC bits above the alignment. A training write with trn_cond set moves the counter up on trn_taken and down otherwise, saturating at 0 and 3.
- R9: A conditional branch with req_cond_ds set that ends not taken gets target PC + 2×INST_BYTES. Other not-taken results get PC + INST_BYTES.
- R10: Each thread stack holds RAS_DEPTH entries in a ring. A push when the stack is full overwrites the oldest entry. Slots fill from index 0 upward after reset and wrap. Pops return values newest first, and after RAS_DEPTH pops the stack reads empty.
- R11: Stacks of different threads are independent. A push or pop on one thread never changes what another thread's return sees.
- R12: cnt_lookup counts control requests, cnt_cond counts conditional ones, cnt_btb_look counts buffer probes, cnt_btb_hit counts hits and cnt_ras_use counts stack pops. Each rises by at most one per cycle, and hits never exceed probes.
- R13: The response (rsp_valid and all rsp_* fields) appears on the first rising edge after the request is accepted. The rsp_* fields hold until the next control request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_pc | input | PC_W | Instruction address |
| req_cond | input | 1 | Conditional branch |
| req_uncond | input | 1 | Unconditional control transfer |
| req_call | input | 1 | Call (pushes return address) |
| req_ret | input | 1 | Return (pops return address) |
| req_direct | input | 1 | Target is encoded in the instruction |
| req_cond_ds | input | 1 | Conditional branch followed by a delay slot |
| req_direct_tgt | input | PC_W | Encoded target |
| req_asid | input | ASID_W | Address-space identifier |
| req_tid | input | TID_W | Hardware thread number |
| trn_valid | input | 1 | Training write present |
| trn_pc | input | PC_W | Address of the resolved branch |
| trn_asid | input | ASID_W | Its address-space identifier |
| trn_cond | input | 1 | Move the direction counter |
| trn_taken | input | 1 | Resolved direction; when 1 the buffer entry is written |
| trn_target | input | PC_W | Resolved target |
| rsp_valid | output | 1 | Response present |
| rsp_taken | output | 1 | Predicted taken |
| rsp_target | output | PC_W | Predicted next fetch address |
| rsp_used_ras | output | 1 | Stack was popped for the target |
| rsp_ras_idx | output | RAS_IDX_W | Slot index popped |
| rsp_ras_tgt | output | PC_W | Value popped |
| rsp_was_call | output | 1 | A call pushed onto the stack |
| cnt_lookup | output | CNT_W | Control lookups |
| cnt_cond | output | CNT_W | Conditional predictions |
| cnt_btb_look | output | CNT_W | Target-buffer probes |
| cnt_btb_hit | output | CNT_W | Target-buffer hits |
| cnt_ras_use | output | CNT_W | Stack pops |

## Verification
The assertions assume well-formed type flags. req_cond and req_uncond are never both set, req_call and req_ret are never both set, and a call or return always has req_uncond set. They also assume a training write never targets the buffer slot read in the same cycle. The directed stimulus builds every request from a fixed set of flag combinations that meet these rules, and it issues each training write in a cycle with no request. Counter overflow is also assumed away, which the short run keeps far from.

// File: rtl/brp_pkg.sv
`timescale 1ns/1ps
// Shared constants and helpers for the branch target prediction unit.
// Assumes: nothing beyond the standard 2-bit saturating counter scheme.
package brp_pkg;

    // Direction counter value loaded at reset (weakly not taken).
    localparam logic [1:0] CTR_WEAK_NT = 2'b01;

    // Saturating step of a 2-bit direction counter.
    function automatic logic [1:0] ctr_next(input logic [1:0] cur, input logic up);
        logic [1:0] nxt;
        nxt = cur;
        if (up && cur != 2'b11)
            nxt = cur + 2'b01;
        else if (!up && cur != 2'b00)
            nxt = cur - 2'b01;
        return nxt;
    endfunction

endpackage

// File: rtl/brp_dirtab.sv
`timescale 1ns/1ps
// Direction table: ENTRIES 2-bit saturating counters. The read is combinational
// and the training write is clocked.
// Assumes: ENTRIES is a power of two; index slices are cut by the parent.
module brp_dirtab #(
    parameter int ENTRIES = 256,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    import brp_pkg::*;

    logic [1:0] ctr [ENTRIES];

    // Reset all counters to weakly not taken, else train one counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++)
                ctr[i] <= CTR_WEAK_NT;
        end else if (wr_en) begin
            ctr[wr_idx] <= ctr_next(ctr[wr_idx], wr_taken);
        end
    end

    assign rd_taken = ctr[rd_idx][1];

endmodule

// File: rtl/brp_btb.sv
`timescale 1ns/1ps
// Direct-mapped branch target buffer. An entry matches on the ASID and on every
// PC bit outside the index, so threads sharing an address space share entries.
// Assumes: ENTRIES is a power of two, ALIGN >= 1.
module brp_btb #(
    parameter int PC_W    = 32,
    parameter int ASID_W  = 8,
    parameter int ENTRIES = 64,
    parameter int ALIGN   = 2,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = PC_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   rd_pc,
    input  logic [ASID_W-1:0] rd_asid,
    output logic              rd_hit,
    output logic [PC_W-1:0]   rd_tgt,
    input  logic              wr_en,
    input  logic [PC_W-1:0]   wr_pc,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PC_W-1:0]   wr_tgt
);
    logic [ENTRIES-1:0] vld;
    logic [ASID_W-1:0]  asid_m [ENTRIES];
    logic [TAG_W-1:0]   tag_m  [ENTRIES];
    logic [PC_W-1:0]    tgt_m  [ENTRIES];

    function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] pc);
        return {pc[PC_W-1:ALIGN+IDX_W], pc[ALIGN-1:0]};
    endfunction

    wire [IDX_W-1:0] ridx = rd_pc[ALIGN +: IDX_W];
    wire [IDX_W-1:0] widx = wr_pc[ALIGN +: IDX_W];

    // Valid bits: cleared by reset, set by a training write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld <= '0;
        else if (wr_en)
            vld[widx] <= 1'b1;
    end

    // Entry payload: written on training, not reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            asid_m[widx] <= wr_asid;
            tag_m[widx]  <= tag_of(wr_pc);
            tgt_m[widx]  <= wr_tgt;
        end
    end

    assign rd_hit = vld[ridx] && (asid_m[ridx] == rd_asid) && (tag_m[ridx] == tag_of(rd_pc));
    assign rd_tgt = tgt_m[ridx];

endmodule

// File: rtl/brp_ras.sv
`timescale 1ns/1ps
// Per-thread circular return-address stacks. Push and pop act on the selected
// thread only. A push when full overwrites the oldest slot. The empty flag
// comes from an occupancy counter.
// Assumes: DEPTH is a power of two; push and pop are never both set.
module brp_ras #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 16,
    parameter int NTHR  = 2,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TID_W-1:0] tid,
    input  logic             push,
    input  logic [PC_W-1:0]  push_val,
    input  logic             pop,
    output logic             empty,
    output logic [IDX_W-1:0] top_idx,
    output logic [PC_W-1:0]  top_val
);
    localparam logic [IDX_W-1:0] ONE_I  = IDX_W'(1);
    localparam logic [IDX_W:0]   ONE_O  = (IDX_W+1)'(1);
    localparam logic [IDX_W:0]   FULL   = (IDX_W+1)'(DEPTH);
    localparam logic [IDX_W-1:0] TOP_RS = IDX_W'(DEPTH-1);

    logic [NTHR-1:0] emp_v;
    logic [IDX_W-1:0] idx_v [NTHR];
    logic [PC_W-1:0]  val_v [NTHR];

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        logic [PC_W-1:0]  mem [DEPTH];
        logic [IDX_W-1:0] tp;
        logic [IDX_W:0]   occ;
        wire sel = (tid == TID_W'(t));

        // Top pointer and occupancy: a push advances, a pop retreats if not empty.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tp  <= TOP_RS;
                occ <= '0;
            end else if (sel && push) begin
                tp  <= tp + ONE_I;
                occ <= (occ == FULL) ? occ : occ + ONE_O;
            end else if (sel && pop && occ != '0) begin
                tp  <= tp - ONE_I;
                occ <= occ - ONE_O;
            end
        end

        // Slot storage: a push writes the slot after the current top.
        always_ff @(posedge clk) begin
            if (sel && push)
                mem[tp + ONE_I] <= push_val;
        end

        assign emp_v[t] = (occ == '0);
        assign idx_v[t] = tp;
        assign val_v[t] = mem[tp];
    end

    assign empty   = emp_v[tid];
    assign top_idx = idx_v[tid];
    assign top_val = val_v[tid];

endmodule

// File: rtl/brp_unit.sv
`timescale 1ns/1ps
// Branch target prediction unit. The decision for a control request is made
// combinationally from the direction table, the thread stack and the target
// buffer, then registered one cycle later together with a repair record and the
// event counters.
// Assumes: well-formed flags (call/return imply unconditional, cond and uncond
// exclusive), INST_BYTES a power of two >= 2.
module brp_unit #(
    parameter int PC_W        = 32,
    parameter int ASID_W      = 8,
    parameter int NTHR        = 2,
    parameter int BTB_ENTRIES = 64,
    parameter int DIR_ENTRIES = 256,
    parameter int RAS_DEPTH   = 16,
    parameter int INST_BYTES  = 4,
    parameter int DELAY_SLOT  = 1,
    parameter int CNT_W       = 32,
    localparam int TID_W      = (NTHR > 1) ? $clog2(NTHR) : 1,
    localparam int RAS_IDX_W  = $clog2(RAS_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [PC_W-1:0]      req_pc,
    input  logic                 req_cond,
    input  logic                 req_uncond,
    input  logic                 req_call,
    input  logic                 req_ret,
    input  logic                 req_direct,
    input  logic                 req_cond_ds,
    input  logic [PC_W-1:0]      req_direct_tgt,
    input  logic [ASID_W-1:0]    req_asid,
    input  logic [TID_W-1:0]     req_tid,
    input  logic                 trn_valid,
    input  logic [PC_W-1:0]      trn_pc,
    input  logic [ASID_W-1:0]    trn_asid,
    input  logic                 trn_cond,
    input  logic                 trn_taken,
    input  logic [PC_W-1:0]      trn_target,
    output logic                 rsp_valid,
    output logic                 rsp_taken,
    output logic [PC_W-1:0]      rsp_target,
    output logic                 rsp_used_ras,
    output logic [RAS_IDX_W-1:0] rsp_ras_idx,
    output logic [PC_W-1:0]      rsp_ras_tgt,
    output logic                 rsp_was_call,
    output logic [CNT_W-1:0]     cnt_lookup,
    output logic [CNT_W-1:0]     cnt_cond,
    output logic [CNT_W-1:0]     cnt_btb_look,
    output logic [CNT_W-1:0]     cnt_btb_hit,
    output logic [CNT_W-1:0]     cnt_ras_use
);
    localparam int ALIGN     = $clog2(INST_BYTES);
    localparam int DIR_IDX_W = $clog2(DIR_ENTRIES);
    localparam logic [PC_W-1:0]  STEP     = PC_W'(INST_BYTES);
    localparam logic [PC_W-1:0]  STEP2    = PC_W'(2 * INST_BYTES);
    localparam logic [PC_W-1:0]  CALL_OFS = PC_W'((DELAY_SLOT != 0) ? 2 * INST_BYTES : INST_BYTES);
    localparam logic [CNT_W-1:0] C1       = CNT_W'(1);

    logic                 dir_taken;
    logic                 btb_hit;
    logic [PC_W-1:0]      btb_tgt;
    logic                 ras_empty;
    logic [RAS_IDX_W-1:0] ras_idx;
    logic [PC_W-1:0]      ras_top;

    logic                 d_taken, d_used, d_call, d_probe, d_hit;
    logic [PC_W-1:0]      d_tgt;

    wire fire = req_valid && (req_cond || req_uncond);

    brp_dirtab #(.ENTRIES(DIR_ENTRIES)) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (req_pc[ALIGN +: DIR_IDX_W]),
        .rd_taken (dir_taken),
        .wr_en    (trn_valid && trn_cond),
        .wr_idx   (trn_pc[ALIGN +: DIR_IDX_W]),
        .wr_taken (trn_taken)
    );

    brp_btb #(.PC_W(PC_W), .ASID_W(ASID_W), .ENTRIES(BTB_ENTRIES), .ALIGN(ALIGN)) u_btb (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_pc   (req_pc),
        .rd_asid (req_asid),
        .rd_hit  (btb_hit),
        .rd_tgt  (btb_tgt),
        .wr_en   (trn_valid && trn_taken),
        .wr_pc   (trn_pc),
        .wr_asid (trn_asid),
        .wr_tgt  (trn_target)
    );

    brp_ras #(.PC_W(PC_W), .DEPTH(RAS_DEPTH), .NTHR(NTHR)) u_ras (
        .clk      (clk),
        .rst_n    (rst_n),
        .tid      (req_tid),
        .push     (fire && d_call),
        .push_val (req_pc + CALL_OFS),
        .pop      (fire && d_used),
        .empty    (ras_empty),
        .top_idx  (ras_idx),
        .top_val  (ras_top)
    );

    // Decision: direction first, then target source, then not-taken fall-through.
    always_comb begin
        d_used  = 1'b0;
        d_call  = 1'b0;
        d_probe = 1'b0;
        d_hit   = 1'b0;
        d_tgt   = req_pc + STEP;
        if (req_uncond)
            d_taken = !(req_ret && ras_empty);
        else
            d_taken = dir_taken;
        if (d_taken) begin
            if (req_ret) begin
                d_used = 1'b1;
                d_tgt  = ras_top;
            end else begin
                d_probe = 1'b1;
                if (req_call)
                    d_call = 1'b1;
                if (req_call && req_direct) begin
                    d_tgt = req_direct_tgt;
                end else if (btb_hit) begin
                    d_hit = 1'b1;
                    d_tgt = btb_tgt;
                end else begin
                    d_taken = 1'b0;
                end
            end
        end
        if (!d_taken)
            d_tgt = (req_cond && req_cond_ds) ? req_pc + STEP2 : req_pc + STEP;
    end

    // Response register: valid pulses per control request, fields hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_taken    <= 1'b0;
            rsp_target   <= '0;
            rsp_used_ras <= 1'b0;
            rsp_ras_idx  <= '0;
            rsp_ras_tgt  <= '0;
            rsp_was_call <= 1'b0;
        end else begin
            rsp_valid <= fire;
            if (fire) begin
                rsp_taken    <= d_taken;
                rsp_target   <= d_tgt;
                rsp_used_ras <= d_used;
                rsp_ras_idx  <= d_used ? ras_idx : '0;
                rsp_ras_tgt  <= d_used ? ras_top : '0;
                rsp_was_call <= d_call;
            end
        end
    end

    // Event counters, one step per qualifying control request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_lookup   <= '0;
            cnt_cond     <= '0;
            cnt_btb_look <= '0;
            cnt_btb_hit  <= '0;
            cnt_ras_use  <= '0;
        end else if (fire) begin
            cnt_lookup <= cnt_lookup + C1;
            if (req_cond) cnt_cond     <= cnt_cond + C1;
            if (d_probe)  cnt_btb_look <= cnt_btb_look + C1;
            if (d_hit)    cnt_btb_hit  <= cnt_btb_hit + C1;
            if (d_used)   cnt_ras_use  <= cnt_ras_use + C1;
        end
    end

endmodule

// File: rtl/brp_unit_chk.sv
`timescale 1ns/1ps
// Property checker for brp_unit, attached by bind. Observes ports only.
// Assumes: well-formed request flags, as stated for the top module.
module brp_unit_chk #(
    parameter int PC_W  = 32,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_cond,
    input logic             req_uncond,
    input logic             req_call,
    input logic             req_ret,
    input logic             req_direct,
    input logic [PC_W-1:0]  req_direct_tgt,
    input logic             rsp_valid,
    input logic             rsp_taken,
    input logic [PC_W-1:0]  rsp_target,
    input logic             rsp_used_ras,
    input logic [CNT_W-1:0] cnt_lookup,
    input logic [CNT_W-1:0] cnt_btb_look,
    input logic [CNT_W-1:0] cnt_btb_hit
);
    // R13: a response follows a control request by exactly one cycle.
    a_r13_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && (req_cond || req_uncond)));

    // R2: a request without control flags gives no response.
    a_r2_no_ctl_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_cond && !req_uncond) |=> !rsp_valid);

    // R4: a direct call is taken to its encoded target.
    a_r4_direct_call: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_uncond && req_call && req_direct && !req_ret)
        |=> (rsp_taken && rsp_target == $past(req_direct_tgt)));

    // R5: using the stack always yields a taken guess.
    a_r5_ras_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_used_ras) |-> rsp_taken);

    // R12: hits never exceed probes.
    a_r12_hit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_btb_hit <= cnt_btb_look);

    // R12: the lookup counter steps by at most one.
    a_r12_lookup_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_lookup == $past(cnt_lookup) || cnt_lookup == $past(cnt_lookup) + CNT_W'(1)));

endmodule

bind brp_unit brp_unit_chk #(.PC_W(PC_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_brp_unit.sv
`timescale 1ns/1ps
// Directed bench for brp_unit: one task per scenario, each checking its own results.
module sim_brp_unit;
    localparam int F_COND = 1, F_UNC = 2, F_CALL = 4, F_RET = 8, F_DIR = 16, F_DS = 32;
    localparam int JCALL = F_UNC | F_CALL | F_DIR;
    localparam int ICALL = F_UNC | F_CALL;
    localparam int RET   = F_UNC | F_RET;
    localparam int JIND  = F_UNC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_cond = 1'b0, req_uncond = 1'b0, req_call = 1'b0;
    logic        req_ret = 1'b0, req_direct = 1'b0, req_cond_ds = 1'b0;
    logic [31:0] req_pc = '0, req_direct_tgt = '0;
    logic [7:0]  req_asid = '0;
    logic        req_tid = 1'b0;
    logic        trn_valid = 1'b0, trn_cond = 1'b0, trn_taken = 1'b0;
    logic [31:0] trn_pc = '0, trn_target = '0;
    logic [7:0]  trn_asid = '0;
    logic        rsp_valid, rsp_taken, rsp_used_ras, rsp_was_call;
    logic [31:0] rsp_target, rsp_ras_tgt;
    logic [3:0]  rsp_ras_idx;
    logic [31:0] cnt_lookup, cnt_cond, cnt_btb_look, cnt_btb_hit, cnt_ras_use;

    int n_chk = 0, n_bad = 0;
    int e_look = 0, e_cond = 0, e_bl = 0, e_bh = 0, e_ras = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    brp_unit u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input string req, input logic [31:0] pc, input int fl,
                         input logic [31:0] dtgt, input logic [7:0] asid, input logic tid,
                         input logic ev, input logic et, input logic [31:0] etgt,
                         input logic eused, input logic eprobe, input logic ehit);
        @(negedge clk);
        req_valid = 1'b1; req_pc = pc; req_direct_tgt = dtgt; req_asid = asid; req_tid = tid;
        req_cond = (fl & F_COND) != 0; req_uncond = (fl & F_UNC) != 0;
        req_call = (fl & F_CALL) != 0; req_ret = (fl & F_RET) != 0;
        req_direct = (fl & F_DIR) != 0; req_cond_ds = (fl & F_DS) != 0;
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " valid"}, 32'(rsp_valid), 32'(ev));
        if (ev) begin
            chk({req, " taken"}, 32'(rsp_taken), 32'(et));
            chk({req, " target"}, rsp_target, etgt);
            chk({req, " used_ras"}, 32'(rsp_used_ras), 32'(eused));
            chk({req, " was_call"}, 32'(rsp_was_call), 32'(eprobe && ((fl & F_CALL) != 0)));
            e_look++;
            if ((fl & F_COND) != 0) e_cond++;
            if (eprobe) e_bl++;
            if (ehit) e_bh++;
            if (eused) e_ras++;
        end
    endtask

    task automatic train(input logic [31:0] pc, input logic [7:0] asid, input logic c,
                         input logic t, input logic [31:0] tgt);
        @(negedge clk);
        trn_valid = 1'b1; trn_pc = pc; trn_asid = asid; trn_cond = c; trn_taken = t; trn_target = tgt;
        @(negedge clk);
        trn_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 cnt_lookup", cnt_lookup, 0);
        chk("R1 cnt_btb_hit", cnt_btb_hit, 0);
        chk("R1 cnt_ras_use", cnt_ras_use, 0);
    endtask

    task automatic t_nonctl();
        issue("R2 non-control", 32'h100, F_CALL, 32'h900, 8'd1, 1'b0, 0, 0, 0, 0, 0, 0);
        chk("R2 lookups unchanged", cnt_lookup, 0);
        issue("R6 R2 empty return", 32'h104, RET, 0, 8'd1, 1'b0, 1, 0, 32'h108, 0, 0, 0);
    endtask

    task automatic t_call_ret();
        issue("R4 direct call", 32'h1000, JCALL, 32'h2000, 8'd1, 1'b0, 1, 1, 32'h2000, 0, 1, 0);
        issue("R3 R5 return", 32'h2010, RET, 0, 8'd1, 1'b0, 1, 1, 32'h1008, 1, 0, 0);
        chk("R5 ras_idx", 32'(rsp_ras_idx), 0);
        chk("R5 ras_tgt", rsp_ras_tgt, 32'h1008);
    endtask

    task automatic t_threads();
        issue("R11 call t1", 32'h3000, JCALL, 32'h3100, 8'd1, 1'b1, 1, 1, 32'h3100, 0, 1, 0);
        issue("R11 ret t0 empty", 32'h3104, RET, 0, 8'd1, 1'b0, 1, 0, 32'h3108, 0, 0, 0);
        issue("R11 ret t1", 32'h3104, RET, 0, 8'd1, 1'b1, 1, 1, 32'h3008, 1, 0, 0);
    endtask

    task automatic t_btb();
        train(32'h4000, 8'd5, 1'b0, 1'b1, 32'h5000);
        issue("R7 hit t0", 32'h4000, JIND, 0, 8'd5, 1'b0, 1, 1, 32'h5000, 0, 1, 1);
        issue("R7 hit t1 same asid", 32'h4000, JIND, 0, 8'd5, 1'b1, 1, 1, 32'h5000, 0, 1, 1);
        issue("R7 asid miss", 32'h4000, JIND, 0, 8'd6, 1'b0, 1, 0, 32'h4004, 0, 1, 0);
        issue("R7 tag miss", 32'h4100, JIND, 0, 8'd5, 1'b0, 1, 0, 32'h4104, 0, 1, 0);
        issue("R7 R3 indirect call", 32'h4000, ICALL, 0, 8'd5, 1'b0, 1, 1, 32'h5000, 0, 1, 1);
        issue("R3 return after icall", 32'h5010, RET, 0, 8'd5, 1'b0, 1, 1, 32'h4008, 1, 0, 0);
    endtask

    task automatic t_cond();
        issue("R8 weak nt", 32'h6000, F_COND, 0, 8'd5, 1'b0, 1, 0, 32'h6004, 0, 0, 0);
        issue("R9 delay slot nt", 32'h6000, F_COND | F_DS, 0, 8'd5, 1'b0, 1, 0, 32'h6008, 0, 0, 0);
        train(32'h6000, 8'd5, 1'b1, 1'b1, 32'h7000);
        issue("R8 trained taken", 32'h6000, F_COND, 0, 8'd5, 1'b0, 1, 1, 32'h7000, 0, 1, 1);
        issue("R8 taken btb miss", 32'h6000, F_COND, 0, 8'd9, 1'b0, 1, 0, 32'h6004, 0, 1, 0);
        issue("R9 ds btb miss", 32'h6000, F_COND | F_DS, 0, 8'd9, 1'b0, 1, 0, 32'h6008, 0, 1, 0);
        train(32'h6000, 8'd5, 1'b1, 1'b0, 0);
        train(32'h6000, 8'd5, 1'b1, 1'b0, 0);
        issue("R8 trained nt", 32'h6000, F_COND, 0, 8'd5, 1'b0, 1, 0, 32'h6004, 0, 0, 0);
        for (int i = 0; i < 4; i++) train(32'h6000, 8'd5, 1'b1, 1'b1, 32'h7000);
        train(32'h6000, 8'd5, 1'b1, 1'b0, 0);
        issue("R8 saturate top", 32'h6000, F_COND, 0, 8'd5, 1'b0, 1, 1, 32'h7000, 0, 1, 1);
    endtask

    task automatic t_ring();
        for (int i = 0; i <= 16; i++)
            issue("R10 push", 32'h8000 + 32'(i * 16), JCALL, 32'h9000, 8'd1, 1'b0,
                  1, 1, 32'h9000, 0, 1, 0);
        for (int k = 0; k < 16; k++) begin
            issue("R10 pop", 32'hA000, RET, 0, 8'd1, 1'b0, 1, 1,
                  32'h8008 + 32'((16 - k) * 16), 1, 0, 0);
            if (k == 0) chk("R10 wrap idx", 32'(rsp_ras_idx), 0);
        end
        issue("R10 drained", 32'hA000, RET, 0, 8'd1, 1'b0, 1, 0, 32'hA004, 0, 0, 0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        req_valid = 1'b1; req_pc = 32'h6000; req_asid = 8'd5; req_tid = 1'b0;
        req_cond = 1'b1; req_uncond = 1'b0; req_call = 1'b0; req_ret = 1'b0;
        req_direct = 1'b0; req_cond_ds = 1'b0;
        #1;
        chk("R13 not before edge", 32'(rsp_valid), 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R13 after edge", 32'(rsp_valid), 1);
        chk("R13 target", rsp_target, 32'h7000);
        e_look++; e_cond++; e_bl++; e_bh++;
        @(negedge clk);
        chk("R13 valid drops", 32'(rsp_valid), 0);
        chk("R13 fields hold", rsp_target, 32'h7000);
    endtask

    task automatic t_counters();
        chk("R12 lookups", cnt_lookup, 32'(e_look));
        chk("R12 cond", cnt_cond, 32'(e_cond));
        chk("R12 btb probes", cnt_btb_look, 32'(e_bl));
        chk("R12 btb hits", cnt_btb_hit, 32'(e_bh));
        chk("R12 ras uses", cnt_ras_use, 32'(e_ras));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_nonctl();
        t_call_ret();
        t_threads();
        t_btb();
        t_cond();
        t_ring();
        t_latency();
        t_counters();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule